// File: doc/BRIEF.md
# I2C Bus Occupancy Monitor

This block listens to the clock and data lines of an I2C bus. A fast system clock oversamples both lines. From them the block keeps a single busy flag, so that a local master can tell whether it may begin a transfer without disturbing traffic that is already on the wire. Each line passes through a synchronizer and a small majority filter. Start and stop conditions are then decoded from the cleaned levels. The block emits one-cycle strobes for them and an optional interrupt pulse when a stop is seen.

When the block is switched on, the busy flag is not taken from the lines. A configuration input chooses the flag's value: pessimistic (busy until a stop proves otherwise) or optimistic (free at once). If the block comes up while the data line is already low and the clock line is high, it reads that as a start. A local-release input withdraws the block from the transfer it has joined. The block stays out until the bus is released. A one-deep request register accepts a start or a stop request. It ignores further requests until the pending one is satisfied by the matching bus condition. The block does not shift bytes, drive acknowledges, stretch the clock or arbitrate.

Top module: `i2c_bus_monitor`

## Requirements
- R1: When `enable` rises with `init_free` = 0, `bus_busy` is 1 one cycle later, whatever the line levels.
- R2: When `enable` rises with `init_free` = 1, `bus_busy` is 0 one cycle later, whatever the line levels.
- R3: A start (data falls while clock is high) sets `bus_busy` and pulses `start_det` for exactly one cycle. A stop (data rises while clock is high) clears `bus_busy` and pulses `stop_det` for one cycle. Data changes while clock is low produce neither.
- R4: Enabling the block while data is low and clock is high yields a `start_det` pulse 3 cycles after `enable` rises, and `bus_busy` becomes 1.
- R5: `stop_irq` pulses in the same cycle as `stop_det` when `stop_irq_en` is 1, and stays 0 when it is 0.
- R6: `engaged` goes to 1 on a start and to 0 on a stop. A `local_release` clears it the next cycle, and it stays 0 through any further starts until a stop is seen. A release issued 5 cycles after enable is honoured.
- R7: A start or stop request is accepted only while none is pending. A pending start clears on a detected start, and a pending stop clears on a detected stop. A request of either kind written while one is pending is ignored.
- R8: With `enable` low, `bus_busy`, `engaged`, the strobes, `stop_irq` and both pending flags are 0 one cycle later.
- R9: `start_ok` is 1 exactly when `enable` is 1 and `bus_busy` is 0.
- R10: A line change reaches the strobes 5 cycles after it is applied. A low pulse on data lasting one cycle is rejected by the majority filter and produces no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| init_free | input | 1 | Busy flag value on enable: 0 busy, 1 free |
| stop_irq_en | input | 1 | Allows the stop interrupt pulse |
| start_req | input | 1 | Start request write strobe |
| stop_req | input | 1 | Stop request write strobe |
| local_release | input | 1 | Withdraws the block from the current transfer |
| sda_i | input | 1 | Raw data line level |
| scl_i | input | 1 | Raw clock line level |
| bus_busy | output | 1 | Bus occupied flag |
| start_ok | output | 1 | Local master may start |
| start_det | output | 1 | One-cycle start strobe |
| stop_det | output | 1 | One-cycle stop strobe |
| stop_irq | output | 1 | Stop interrupt request pulse |
| engaged | output | 1 | Block takes part in the current transfer |
| start_pend | output | 1 | Start request pending |
| stop_pend | output | 1 | Stop request pending |

## Verification
The hardest case to reach is an enable that arrives while the data line is already held low under a high clock. The synchronizer has to be pre-loaded with those levels while the block is disabled, and then `enable` raised on a known cycle. Only then can the start pulse be checked 3 cycles later and a release placed inside the window after enable. The bench parks the lines in that state for several cycles while disabled and then steps `enable` at a negative edge. After that it runs random sequences of starts, stops and data bits against an operation-level model of the flag and the event counts.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  // Filtered line levels
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  // Combinational bus conditions
  typedef struct packed {
    logic start;
    logic stop;
  } bus_events_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic line_i,
  output logic line_o
);

  localparam int HALF = TAPS / 2;
  localparam int CW   = $clog2(TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [TAPS-1:0]        hist_q, hist_d;
  logic [CW-1:0]          ones;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    // history is held at idle-high while disabled
    hist_d = enable ? {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]} : '1;
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + CW'(hist_q[i]);
    end
  end

  assign line_o = (ones > CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> line_o); // R8

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  bus_lines_t  lines_i,
  output bus_events_t events_o,
  output logic        start_det_o,
  output logic        stop_det_o
);

  bus_lines_t prev_q, prev_d;
  logic       start_q, start_d;
  logic       stop_q, stop_d;

  always_comb begin
    events_o.start = enable && prev_q.scl && lines_i.scl && prev_q.sda && !lines_i.sda;
    events_o.stop  = enable && prev_q.scl && lines_i.scl && !prev_q.sda && lines_i.sda;
    prev_d  = enable ? lines_i : '1;
    start_d = events_o.start;
    stop_d  = events_o.stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign start_det_o = start_q;
  assign stop_det_o  = stop_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det_o |=> !start_det_o); // R3
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det_o |=> !stop_det_o); // R3
  AST_NO_BOTH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det_o && stop_det_o)); // R3

endmodule

// File: rtl/i2c_bus_state.sv
module i2c_bus_state
  import i2c_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        init_free,
  input  logic        stop_irq_en,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        local_release,
  input  bus_events_t events_i,
  output logic        bus_busy,
  output logic        start_ok,
  output logic        engaged,
  output logic        stop_irq,
  output logic        start_pend,
  output logic        stop_pend
);

  logic en_q;
  logic busy_q, busy_d;
  logic eng_q, eng_d;
  logic hold_q, hold_d;
  logic irq_q, irq_d;
  logic spnd_q, spnd_d;
  logic ppnd_q, ppnd_d;
  logic accept;

  assign accept = enable && !spnd_q && !ppnd_q;

  always_comb begin
    busy_d = busy_q;
    if (!enable)             busy_d = 1'b0;
    else if (!en_q)          busy_d = !init_free;
    else if (events_i.start) busy_d = 1'b1;
    else if (events_i.stop)  busy_d = 1'b0;
  end

  always_comb begin
    hold_d = hold_q;
    eng_d  = eng_q;
    if (!enable) begin
      hold_d = 1'b0;
      eng_d  = 1'b0;
    end else if (local_release) begin
      hold_d = 1'b1;
      eng_d  = 1'b0;
    end else if (events_i.stop) begin
      hold_d = 1'b0;
      eng_d  = 1'b0;
    end else if (events_i.start && !hold_q) begin
      eng_d  = 1'b1;
    end
  end

  always_comb begin
    irq_d  = enable && events_i.stop && stop_irq_en;
    spnd_d = spnd_q;
    ppnd_d = ppnd_q;
    if (!enable) begin
      spnd_d = 1'b0;
      ppnd_d = 1'b0;
    end else begin
      if (spnd_q && events_i.start)     spnd_d = 1'b0;
      else if (accept && start_req)     spnd_d = 1'b1;
      if (ppnd_q && events_i.stop)      ppnd_d = 1'b0;
      else if (accept && stop_req && !start_req) ppnd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      eng_q  <= 1'b0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
      spnd_q <= 1'b0;
      ppnd_q <= 1'b0;
    end else begin
      en_q   <= enable;
      busy_q <= busy_d;
      eng_q  <= eng_d;
      hold_q <= hold_d;
      irq_q  <= irq_d;
      spnd_q <= spnd_d;
      ppnd_q <= ppnd_d;
    end
  end

  assign bus_busy   = busy_q;
  assign start_ok   = enable && !busy_q;
  assign engaged    = eng_q;
  assign stop_irq   = irq_q;
  assign start_pend = spnd_q;
  assign stop_pend  = ppnd_q;

  AST_ENABLE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |=> (bus_busy == !$past(init_free))); // R1 R2
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_busy && !engaged && !start_pend && !stop_pend && !stop_irq)); // R8
  AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pend && stop_pend)); // R7
  AST_PEND_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pend && enable) |=> !stop_pend); // R7
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (local_release && enable) |=> !engaged); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_irq_en && en_q) |=> !stop_irq); // R5

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic init_free,
  input  logic stop_irq_en,
  input  logic start_req,
  input  logic stop_req,
  input  logic local_release,
  input  logic sda_i,
  input  logic scl_i,
  output logic bus_busy,
  output logic start_ok,
  output logic start_det,
  output logic stop_det,
  output logic stop_irq,
  output logic engaged,
  output logic start_pend,
  output logic stop_pend
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  bus_lines_t        lines;
  bus_events_t       events;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(enable),
      .line_i(raw_lines[g]),
      .line_o(clean_lines[g])
    );
  end

  assign lines.sda = clean_lines[0];
  assign lines.scl = clean_lines[1];

  i2c_cond_detect u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .lines_i    (lines),
    .events_o   (events),
    .start_det_o(start_det),
    .stop_det_o (stop_det)
  );

  i2c_bus_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .init_free    (init_free),
    .stop_irq_en  (stop_irq_en),
    .start_req    (start_req),
    .stop_req     (stop_req),
    .local_release(local_release),
    .events_i     (events),
    .bus_busy     (bus_busy),
    .start_ok     (start_ok),
    .engaged      (engaged),
    .stop_irq     (stop_irq),
    .start_pend   (start_pend),
    .stop_pend    (stop_pend)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> bus_busy); // R3
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> !bus_busy); // R3
  AST_IRQ_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> stop_det); // R5

endmodule

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;

  logic clk = 1'b0;
  logic rst_n, enable, init_free, stop_irq_en, start_req, stop_req, local_release;
  logic sda, scl;
  logic bus_busy, start_ok, start_det, stop_det, stop_irq, engaged, start_pend, stop_pend;

  int n_tests = 0;
  int n_fail  = 0;
  int n_start = 0;
  int n_stop  = 0;
  int n_irq   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  i2c_bus_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .init_free(init_free),
    .stop_irq_en(stop_irq_en), .start_req(start_req), .stop_req(stop_req),
    .local_release(local_release), .sda_i(sda), .scl_i(scl),
    .bus_busy(bus_busy), .start_ok(start_ok), .start_det(start_det),
    .stop_det(stop_det), .stop_irq(stop_irq), .engaged(engaged),
    .start_pend(start_pend), .stop_pend(stop_pend)
  );

  always @(negedge clk) begin
    if (start_det === 1'b1) n_start++;
    if (stop_det === 1'b1)  n_stop++;
    if (stop_irq === 1'b1)  n_irq++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_lines(input logic s, input logic c);
    sda = s;
    scl = c;
    cycles(8);
  endtask

  task automatic do_start();
    set_lines(sda, 1'b0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    set_lines(1'b0, 1'b1);
    set_lines(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    set_lines(sda, 1'b0);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
  endtask

  task automatic do_bit(input logic b);
    set_lines(sda, 1'b0);
    set_lines(b, 1'b0);
    set_lines(b, 1'b1);
    set_lines(b, 1'b0);
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1;
    cycles(1);
    sig = 1'b0;
  endtask

  function automatic int exp_ok(input logic en, input logic busy);
    return (en && !busy) ? 1 : 0;
  endfunction

  function automatic int bool(input logic v);
    return (v === 1'b1) ? 1 : 0;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    int s0, p0, i0;
    logic exp_busy;
    void'($urandom(32'h1f2c_0a5d));
    rst_n = 1'b0; enable = 1'b0; init_free = 1'b0; stop_irq_en = 1'b0;
    start_req = 1'b0; stop_req = 1'b0; local_release = 1'b0;
    sda = 1'b1; scl = 1'b1;
    cycles(3);
    // reset state (R8)
    check("R8 reset busy", bool(bus_busy), 0);
    check("R8 reset outs", bool(start_det | stop_det | stop_irq | engaged | start_pend | stop_pend), 0);
    check("R9 reset start_ok", bool(start_ok), 0);
    rst_n = 1'b1;
    cycles(2);

    // R1: pessimistic enable on idle lines
    init_free = 1'b0; enable = 1'b1;
    cycles(1);
    check("R1 busy on enable", bool(bus_busy), 1);
    check("R9 start_ok while busy", bool(start_ok), 0);
    cycles(10);
    check("R1 busy held without stop", bool(bus_busy), 1);
    do_start();
    check("R3 busy after start", bool(bus_busy), 1);
    do_stop();
    check("R3 busy cleared by stop", bool(bus_busy), 0);
    check("R9 start_ok after stop", bool(start_ok), 1);
    enable = 1'b0;
    cycles(1);
    check("R9 start_ok when disabled", bool(start_ok), 0);

    // R2: optimistic enable
    set_lines(1'b1, 1'b1);
    init_free = 1'b1; enable = 1'b1;
    cycles(1);
    check("R2 free on enable", bool(bus_busy), 0);
    check("R9 start_ok free", bool(start_ok), 1);
    cycles(8);

    // R10: latency and glitch rejection
    sda = 1'b0;
    cycles(4);
    check("R10 no strobe before latency", bool(start_det), 0);
    cycles(1);
    check("R10 start strobe at latency", bool(start_det), 1);
    check("R3 busy with strobe", bool(bus_busy), 1);
    cycles(1);
    check("R3 start strobe one cycle", bool(start_det), 0);
    cycles(6);
    sda = 1'b1;
    cycles(8);
    check("R3 stop clears busy", bool(bus_busy), 0);
    s0 = n_start;
    sda = 1'b0;
    cycles(1);
    sda = 1'b1;
    cycles(10);
    check("R10 glitch gives no start", n_start - s0, 0);
    check("R10 glitch leaves bus free", bool(bus_busy), 0);
    // data change with clock low is no condition (R3)
    s0 = n_start; p0 = n_stop;
    do_bit(1'b0); do_bit(1'b1); do_bit(1'b0);
    check("R3 data bits no events", (n_start - s0) + (n_stop - p0), 0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);

    // R5: interrupt masking
    stop_irq_en = 1'b0;
    do_start();
    set_lines(1'b0, 1'b1);
    sda = 1'b1;
    cycles(5);
    check("R5 stop strobe masked case", bool(stop_det), 1);
    check("R5 irq masked", bool(stop_irq), 0);
    cycles(3);
    stop_irq_en = 1'b1;
    do_start();
    set_lines(1'b0, 1'b1);
    sda = 1'b1;
    cycles(5);
    check("R5 stop strobe enabled case", bool(stop_det), 1);
    check("R5 irq with stop", bool(stop_irq), 1);
    cycles(1);
    check("R5 irq one cycle", bool(stop_irq), 0);
    cycles(2);

    // R4 / R6: enable while data low, clock high
    enable = 1'b0;
    set_lines(1'b0, 1'b1);
    init_free = 1'b1; enable = 1'b1;
    cycles(1);
    check("R2 free before decode", bool(bus_busy), 0);
    cycles(2);
    check("R4 start on enable", bool(start_det), 1);
    check("R4 busy after enable start", bool(bus_busy), 1);
    check("R6 engaged after start", bool(engaged), 1);
    cycles(2);
    local_release = 1'b1;
    cycles(1);
    local_release = 1'b0;
    check("R6 release drops", bool(engaged), 0);
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    set_lines(1'b1, 1'b1);
    set_lines(1'b0, 1'b1);
    check("R6 stays out on repeated start", bool(engaged), 0);
    check("R3 busy on repeated start", bool(bus_busy), 1);
    set_lines(1'b1, 1'b1);
    check("R6 out after stop", bool(engaged), 0);
    check("R3 free after stop", bool(bus_busy), 0);
    do_start();
    check("R6 engaged on new start", bool(engaged), 1);
    do_stop();
    check("R6 disengaged on stop", bool(engaged), 0);

    // R7: request interlock
    pulse_in(start_req);
    check("R7 start accepted", bool(start_pend), 1);
    pulse_in(stop_req);
    check("R7 stop ignored while start pending", bool(stop_pend), 0);
    pulse_in(start_req);
    check("R7 start still pending", bool(start_pend), 1);
    do_start();
    check("R7 start clears on start", bool(start_pend), 0);
    pulse_in(stop_req);
    check("R7 stop accepted", bool(stop_pend), 1);
    pulse_in(start_req);
    check("R7 start ignored while stop pending", bool(start_pend), 0);
    do_stop();
    check("R7 stop clears on stop", bool(stop_pend), 0);

    // R8: disable mid-transfer
    do_start();
    pulse_in(start_req);
    check("R8 pend before disable", bool(start_pend), 1);
    enable = 1'b0;
    cycles(1);
    check("R8 busy cleared", bool(bus_busy), 0);
    check("R8 engaged cleared", bool(engaged), 0);
    check("R8 pend cleared", bool(start_pend), 0);
    check("R9 start_ok off", bool(start_ok), 0);
    set_lines(1'b1, 1'b1);

    // random operations against an operation-level model
    init_free = 1'b1; enable = 1'b1;
    cycles(2);
    exp_busy = 1'b0;
    s0 = n_start; p0 = n_stop; i0 = n_irq;
    begin
      int es, ep, ei;
      es = 0; ep = 0; ei = 0;
      for (int k = 0; k < 200; k++) begin
        int op;
        op = int'($urandom % 4);
        stop_irq_en = 1'($urandom % 2);
        if (op == 0) begin
          do_start(); es++; exp_busy = 1'b1;
        end else if (op == 1) begin
          do_stop(); ep++; exp_busy = 1'b0;
          if (stop_irq_en) ei++;
        end else begin
          do_bit(1'($urandom % 2));
        end
        if (k % 10 == 0 || op < 2) begin
          check("R3 random busy", bool(bus_busy), int'(exp_busy));
          check("R9 random start_ok", bool(start_ok), exp_ok(1'b1, exp_busy));
        end
      end
      check("R3 random start count", n_start - s0, es);
      check("R3 random stop count", n_stop - p0, ep);
      check("R5 random irq count", n_irq - i0, ei);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule